// File: doc/BRIEF.md
# Bidirectional Host/Local Mailbox with Interrupt Flags

This block holds two 32-bit mailbox words that pass between a host-side register bus and a local (add-on) register bus. The host-to-local word is written by the host and is read-only from the local side. The local-to-host word is written by the local side and read by the host. Both buses present an address, per-byte lane enables and single-cycle read and write strobes. Byte, half-word and full-word accesses are all allowed. An external side port can also load the most significant byte of the local-to-host word.

Local accesses raise events. A local read of the host-to-local word is one event, and a local write of the local-to-host word is the other. Each event sets a sticky pending flag that the host clears by writing a one to it. A host-writable control word holds one enable per event, and the interrupt output is high whenever an enabled flag is pending. Per-lane full flags show which bytes of each mailbox have been written and not yet consumed by the other side. The mailbox data words have no reset value.

Top module: `mbox_pair_top`

## Requirements
- R1: After reset, irq is 0 and the host control word (host offset 0x8) reads as zero: enables, pending flags and all full flags are clear.
- R2: A host write at host offset 0x0 updates only the byte lanes whose h_be bit is set. A local read at local offset 0x0C returns the word with every lane whose l_be bit is 0 forced to zero.
- R3: A local write at local offset 0x1C updates only the enabled byte lanes of the local-to-host word. The host sees the word at host offset 0x4.
- R4: A local write at local offset 0x0C changes neither the host-to-local word nor its full flags.
- R5: An x_ld pulse loads x_byte into bits 31:24 of the local-to-host word. If a local write with l_be[3] set happens in the same cycle, the local write wins that byte, and any other lanes it enables are written as well.
- R6: Full flags sit in the control word. Host-to-local flags are bits 19:16 and local-to-host flags are bits 23:20, bit n for lane n. A flag is set by a write into its lane (host write, local write, or x_ld for lane 3). It is cleared by the other side's read of that lane: a local read at 0x0C, or a host read at 0x4. A set and a clear in the same cycle leave the flag set.
- R7: A local read at 0x0C with any lane enabled sets pending bit 8. A local write at 0x1C with any lane enabled sets pending bit 9. Both flags are set whatever the enables are.
- R8: A local read at 0x1C changes no pending flag, no full flag and irq.
- R9: A host write at 0x8 with h_be[1] set clears each pending flag whose data bit (8 or 9) is 1 and leaves the others. An event in the same cycle as its clear leaves the flag set.
- R10: Enables are bits 1:0 of the control word, written when h_be[0] is set: bit 0 for the read event and bit 1 for the write event. irq is high exactly when some pending flag has its enable set, from the cycle after the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| h_addr | input | HA_W | Host register offset |
| h_be | input | DW/8 | Host byte-lane enables |
| h_wr | input | 1 | Host write strobe |
| h_rd | input | 1 | Host read strobe |
| h_wdata | input | DW | Host write data |
| h_rdata | output | DW | Host read data, lanes masked by h_be |
| l_addr | input | LA_W | Local register offset |
| l_be | input | DW/8 | Local byte-lane enables |
| l_wr | input | 1 | Local write strobe |
| l_rd | input | 1 | Local read strobe |
| l_wdata | input | DW | Local write data |
| l_rdata | output | DW | Local read data, lanes masked by l_be |
| x_ld | input | 1 | External load strobe for the top byte of the local-to-host word |
| x_byte | input | 8 | External byte value |
| irq | output | 1 | Host interrupt request |

## Verification
The bench sweeps every byte-enable pattern on both mailboxes and follows each sweep with a partial read. A design that decodes lanes wrongly would merge stale bytes, and one that clears the wrong full flags would report leftover or missing lanes. It sets up same-cycle collisions: an x_ld against a local write of lane 3, and a set against a clear on both the full flags and the pending flags. A design with the priority reversed would lose a local byte, or drop an event that the host never saw. It also checks that local writes to the read-only word and local reads of the local-to-host word leave the visible state unchanged, and that irq follows the enables both ways.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  timeunit 1ns; timeprecision 1ps;
  localparam int MB_DW   = 32;
  localparam int MB_LA_W = 8;
  localparam int MB_HA_W = 4;
  localparam int MB_NSRC = 2;

  // local-side offsets
  localparam logic [7:0] LOC_IN_OFS  = 8'h0C;
  localparam logic [7:0] LOC_OUT_OFS = 8'h1C;
  // host-side offsets
  localparam logic [7:0] HST_IN_OFS  = 8'h0;
  localparam logic [7:0] HST_OUT_OFS = 8'h4;
  localparam logic [7:0] HST_CTL_OFS = 8'h8;

  // control word field positions
  localparam int CTL_EN_LSB   = 0;
  localparam int CTL_PEND_LSB = 8;
  localparam int CTL_INF_LSB  = 16;
  localparam int CTL_OUTF_LSB = 20;

  typedef enum int { EV_IN_RD = 0, EV_OUT_WR = 1 } mb_event_e;
endpackage

// File: rtl/mbox_bytereg.sv
module mbox_bytereg #(
  parameter int NB = 4
) (
  input  logic          clk,
  input  logic          a_we,
  input  logic [NB-1:0] a_be,
  input  logic [8*NB-1:0] a_d,
  input  logic          b_we,
  input  logic [NB-1:0] b_be,
  input  logic [8*NB-1:0] b_d,
  output logic [8*NB-1:0] q
);
  timeunit 1ns; timeprecision 1ps;
  // Mailbox content has no reset value; port a wins a lane over port b.
  for (genvar i = 0; i < NB; i++) begin : g_lane
    logic       lane_en;
    logic [7:0] lane_nxt;
    always_comb begin
      lane_en  = (a_we & a_be[i]) | (b_we & b_be[i]);
      lane_nxt = (a_we & a_be[i]) ? a_d[8*i +: 8] : b_d[8*i +: 8];
    end
    always_ff @(posedge clk) begin
      if (lane_en) q[8*i +: 8] <= lane_nxt;
    end
  end
endmodule

// File: rtl/mbox_fullbits.sv
module mbox_fullbits #(
  parameter int NB = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NB-1:0] set,
  input  logic [NB-1:0] clr,
  output logic [NB-1:0] q
);
  timeunit 1ns; timeprecision 1ps;
  logic [NB-1:0] nxt;
  always_comb nxt = (q & ~clr) | set;   // set dominates
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= nxt;
  end
endmodule

// File: rtl/mbox_irqctl.sv
module mbox_irqctl #(
  parameter int NSRC = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en_we,
  input  logic [NSRC-1:0] en_d,
  input  logic [NSRC-1:0] ev,
  input  logic [NSRC-1:0] w1c,
  output logic [NSRC-1:0] en_q,
  output logic [NSRC-1:0] pend_q,
  output logic            irq
);
  timeunit 1ns; timeprecision 1ps;
  logic [NSRC-1:0] pend_nxt;
  always_comb pend_nxt = (pend_q & ~w1c) | ev;   // event beats clear

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= '0;
    else if (en_we) en_q <= en_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_nxt;
  end

  assign irq = |(en_q & pend_q);
endmodule

// File: rtl/mbox_pair_top.sv
module mbox_pair_top
  import mbox_pkg::*;
#(
  parameter int DW   = MB_DW,
  parameter int LA_W = MB_LA_W,
  parameter int HA_W = MB_HA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [HA_W-1:0]   h_addr,
  input  logic [DW/8-1:0]   h_be,
  input  logic              h_wr,
  input  logic              h_rd,
  input  logic [DW-1:0]     h_wdata,
  output logic [DW-1:0]     h_rdata,
  input  logic [LA_W-1:0]   l_addr,
  input  logic [DW/8-1:0]   l_be,
  input  logic              l_wr,
  input  logic              l_rd,
  input  logic [DW-1:0]     l_wdata,
  output logic [DW-1:0]     l_rdata,
  input  logic              x_ld,
  input  logic [7:0]        x_byte,
  output logic              irq
);
  timeunit 1ns; timeprecision 1ps;
  localparam int NB   = DW / 8;
  localparam int NSRC = MB_NSRC;
  localparam logic [NB-1:0] TOP_LANE = NB'(1) << (NB - 1);

  // address decode
  logic l_in_hit, l_out_hit, h_in_hit, h_out_hit, h_ctl_hit;
  logic l_rd_in, l_wr_out, h_wr_in, h_rd_out, h_wr_ctl;
  always_comb begin
    l_in_hit  = (l_addr == LA_W'(LOC_IN_OFS));
    l_out_hit = (l_addr == LA_W'(LOC_OUT_OFS));
    h_in_hit  = (h_addr == HA_W'(HST_IN_OFS));
    h_out_hit = (h_addr == HA_W'(HST_OUT_OFS));
    h_ctl_hit = (h_addr == HA_W'(HST_CTL_OFS));
    l_rd_in   = l_rd & l_in_hit;
    l_wr_out  = l_wr & l_out_hit;
    h_wr_in   = h_wr & h_in_hit;
    h_rd_out  = h_rd & h_out_hit;
    h_wr_ctl  = h_wr & h_ctl_hit;
  end

  // mailbox words
  logic [DW-1:0] in_q, out_q;
  mbox_bytereg #(.NB(NB)) u_in_reg (
    .clk(clk), .a_we(h_wr_in), .a_be(h_be), .a_d(h_wdata),
    .b_we(1'b0), .b_be('0), .b_d('0), .q(in_q)
  );
  mbox_bytereg #(.NB(NB)) u_out_reg (
    .clk(clk), .a_we(l_wr_out), .a_be(l_be), .a_d(l_wdata),
    .b_we(x_ld), .b_be(TOP_LANE), .b_d({x_byte, {(DW-8){1'b0}}}), .q(out_q)
  );

  // lane full flags
  logic [NB-1:0] in_set, in_clr, out_set, out_clr, in_full, out_full;
  always_comb begin
    in_set  = h_wr_in  ? h_be : '0;
    in_clr  = l_rd_in  ? l_be : '0;
    out_set = (l_wr_out ? l_be : '0) | (x_ld ? TOP_LANE : '0);
    out_clr = h_rd_out ? h_be : '0;
  end
  mbox_fullbits #(.NB(NB)) u_in_full (
    .clk(clk), .rst_n(rst_n), .set(in_set), .clr(in_clr), .q(in_full)
  );
  mbox_fullbits #(.NB(NB)) u_out_full (
    .clk(clk), .rst_n(rst_n), .set(out_set), .clr(out_clr), .q(out_full)
  );

  // events and interrupt
  logic [NSRC-1:0] ev, w1c, en_q, pend_q;
  always_comb begin
    ev            = '0;
    ev[EV_IN_RD]  = l_rd_in  & (|l_be);
    ev[EV_OUT_WR] = l_wr_out & (|l_be);
    w1c = (h_wr_ctl & h_be[1]) ? h_wdata[CTL_PEND_LSB +: NSRC] : '0;
  end
  mbox_irqctl #(.NSRC(NSRC)) u_irq (
    .clk(clk), .rst_n(rst_n),
    .en_we(h_wr_ctl & h_be[0]), .en_d(h_wdata[CTL_EN_LSB +: NSRC]),
    .ev(ev), .w1c(w1c), .en_q(en_q), .pend_q(pend_q), .irq(irq)
  );

  // read data paths
  logic [DW-1:0] l_mask, h_mask, ctl_word;
  for (genvar i = 0; i < NB; i++) begin : g_mask
    assign l_mask[8*i +: 8] = {8{l_be[i]}};
    assign h_mask[8*i +: 8] = {8{h_be[i]}};
  end

  always_comb begin
    ctl_word = '0;
    ctl_word[CTL_EN_LSB   +: NSRC] = en_q;
    ctl_word[CTL_PEND_LSB +: NSRC] = pend_q;
    ctl_word[CTL_INF_LSB  +: NB]   = in_full;
    ctl_word[CTL_OUTF_LSB +: NB]   = out_full;
  end

  always_comb begin
    if (l_in_hit)       l_rdata = in_q & l_mask;
    else if (l_out_hit) l_rdata = out_q & l_mask;
    else                l_rdata = '0;
    if (h_in_hit)       h_rdata = in_q & h_mask;
    else if (h_out_hit) h_rdata = out_q & h_mask;
    else if (h_ctl_hit) h_rdata = ctl_word & h_mask;
    else                h_rdata = '0;
  end
endmodule

// File: rtl/mbox_pair_chk.sv
module mbox_pair_chk
  import mbox_pkg::*;
#(
  parameter int NB   = 4,
  parameter int NSRC = 2,
  parameter int DW   = 32,
  parameter int LA_W = 8,
  parameter int HA_W = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic [LA_W-1:0] l_addr,
  input logic [NB-1:0]   l_be,
  input logic            l_rd,
  input logic            l_wr,
  input logic [HA_W-1:0] h_addr,
  input logic [NB-1:0]   h_be,
  input logic            h_wr,
  input logic            h_rd,
  input logic [DW-1:0]   h_wdata,
  input logic            x_ld,
  input logic            irq,
  input logic [NSRC-1:0] en_q,
  input logic [NSRC-1:0] pend_q,
  input logic [NB-1:0]   in_full,
  input logic [NB-1:0]   out_full
);
  timeunit 1ns; timeprecision 1ps;

  a_r1_irq_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !irq);

  a_r7_in_read_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (l_rd && l_addr == LA_W'(LOC_IN_OFS) && |l_be) |=> pend_q[EV_IN_RD]);

  a_r7_out_write_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (l_wr && l_addr == LA_W'(LOC_OUT_OFS) && |l_be) |=> pend_q[EV_OUT_WR]);

  a_r9_pend_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q[EV_IN_RD] && !(h_wr && h_addr == HA_W'(HST_CTL_OFS) && h_be[1]
                           && h_wdata[CTL_PEND_LSB + EV_IN_RD]))
    |=> pend_q[EV_IN_RD]);

  a_r8_out_read_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (l_rd && l_addr == LA_W'(LOC_OUT_OFS) && !l_wr && !h_wr && !h_rd && !x_ld)
    |=> ($stable(pend_q) && $stable(in_full) && $stable(out_full)));

  a_r6_in_lane0_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (l_rd && l_addr == LA_W'(LOC_IN_OFS) && l_be[0]
     && !(h_wr && h_addr == HA_W'(HST_IN_OFS) && h_be[0])) |=> !in_full[0]);

  a_r5_ext_load_full: assert property (@(posedge clk) disable iff (!rst_n)
    x_ld |=> out_full[NB-1]);

  a_r10_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0) |-> !irq);
endmodule

bind mbox_pair_top mbox_pair_chk #(
  .NB(NB), .NSRC(NSRC), .DW(DW), .LA_W(LA_W), .HA_W(HA_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .l_addr(l_addr), .l_be(l_be), .l_rd(l_rd),
  .l_wr(l_wr), .h_addr(h_addr), .h_be(h_be), .h_wr(h_wr), .h_rd(h_rd),
  .h_wdata(h_wdata), .x_ld(x_ld), .irq(irq), .en_q(en_q), .pend_q(pend_q),
  .in_full(in_full), .out_full(out_full)
);

// File: tb/sim_mbox_pair_top.sv
module sim_mbox_pair_top;
  timeunit 1ns; timeprecision 1ps;
  localparam int DW = 32, NB = 4, LA_W = 8, HA_W = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic [HA_W-1:0] h_addr;
  logic [NB-1:0]   h_be;
  logic            h_wr, h_rd;
  logic [DW-1:0]   h_wdata, h_rdata;
  logic [LA_W-1:0] l_addr;
  logic [NB-1:0]   l_be;
  logic            l_wr, l_rd;
  logic [DW-1:0]   l_wdata, l_rdata;
  logic            x_ld;
  logic [7:0]      x_byte;
  logic            irq;

  always #5 clk = ~clk;

  mbox_pair_top u0 (
    .clk(clk), .rst_n(rst_n), .h_addr(h_addr), .h_be(h_be), .h_wr(h_wr),
    .h_rd(h_rd), .h_wdata(h_wdata), .h_rdata(h_rdata), .l_addr(l_addr),
    .l_be(l_be), .l_wr(l_wr), .l_rd(l_rd), .l_wdata(l_wdata),
    .l_rdata(l_rdata), .x_ld(x_ld), .x_byte(x_byte), .irq(irq)
  );

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  function automatic logic [31:0] lmask(input logic [3:0] be);
    logic [31:0] m;
    for (int i = 0; i < 4; i++) m[8*i +: 8] = {8{be[i]}};
    return m;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic hw(input logic [3:0] a, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk); h_addr = a; h_be = be; h_wdata = d; h_wr = 1'b1;
    @(posedge clk); #1 h_wr = 1'b0;
  endtask

  task automatic hr(input logic [3:0] a, input logic [3:0] be, output logic [31:0] d);
    @(negedge clk); h_addr = a; h_be = be; h_rd = 1'b1;
    #1 d = h_rdata;
    @(posedge clk); #1 h_rd = 1'b0;
  endtask

  task automatic lw(input logic [7:0] a, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk); l_addr = a; l_be = be; l_wdata = d; l_wr = 1'b1;
    @(posedge clk); #1 l_wr = 1'b0;
  endtask

  task automatic lr(input logic [7:0] a, input logic [3:0] be, output logic [31:0] d);
    @(negedge clk); l_addr = a; l_be = be; l_rd = 1'b1;
    #1 d = l_rdata;
    @(posedge clk); #1 l_rd = 1'b0;
  endtask

  task automatic xl(input logic [7:0] b);
    @(negedge clk); x_byte = b; x_ld = 1'b1;
    @(posedge clk); #1 x_ld = 1'b0;
  endtask

  task automatic st(output logic [31:0] s);
    hr(4'h8, 4'hF, s);
  endtask

  task automatic summary;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog (all requirements): actual hung, expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] d, s, s0, base, pat, mrg;
    logic [3:0]  m;
    h_addr = '0; h_be = '0; h_wr = 0; h_rd = 0; h_wdata = '0;
    l_addr = '0; l_be = '0; l_wr = 0; l_rd = 0; l_wdata = '0;
    x_ld = 0; x_byte = '0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1 reset state
    check("R1 irq", {31'b0, irq}, 32'h0);
    st(s);
    check("R1 control word", s, 32'h0);

    // R2 / R6 host-to-local sweep over all byte enables
    for (int be = 0; be < 16; be++) begin
      base = 32'h1122_3344 + be * 32'h0101_0101;
      pat  = ~base ^ (be * 32'h0001_0203);
      mrg  = (pat & lmask(4'(be))) | (base & ~lmask(4'(be)));
      hw(4'h0, 4'hF, base);
      lr(8'h0C, 4'hF, d);
      hw(4'h0, 4'(be), pat);
      st(s);
      check("R6 in_full after host write", {28'b0, s[19:16]}, {28'b0, 4'(be)});
      m = 4'(be) ^ 4'b0011;
      lr(8'h0C, m, d);
      check("R2 masked local read", d, mrg & lmask(m));
      st(s);
      check("R6 in_full after partial read", {28'b0, s[19:16]}, {28'b0, 4'(be) & ~m});
      lr(8'h0C, 4'hF, d);
      check("R2 merged word", d, mrg);
    end

    // R3 / R6 local-to-host sweep
    for (int be = 0; be < 16; be++) begin
      base = 32'hA0B0_C0D0 ^ (be * 32'h1000_0001);
      pat  = 32'h5F4E_3D2C + be * 32'h0303_0303;
      mrg  = (pat & lmask(4'(be))) | (base & ~lmask(4'(be)));
      lw(8'h1C, 4'hF, base);
      hr(4'h4, 4'hF, d);
      lw(8'h1C, 4'(be), pat);
      st(s);
      check("R6 out_full after local write", {28'b0, s[23:20]}, {28'b0, 4'(be)});
      hr(4'h4, 4'hF, d);
      check("R3 merged word", d, mrg);
      st(s);
      check("R6 out_full after host read", {28'b0, s[23:20]}, 32'h0);
    end

    // R4 local write to host-to-local word is ignored
    hw(4'h0, 4'hF, 32'hA5A5_0F0F);
    lw(8'h0C, 4'hF, 32'hFFFF_FFFF);
    st(s);
    check("R4 in_full untouched", {28'b0, s[19:16]}, 32'hF);
    lr(8'h0C, 4'hF, d);
    check("R4 word untouched", d, 32'hA5A5_0F0F);

    // R5 external byte load and priority
    lw(8'h1C, 4'hF, 32'h0102_0304);
    hr(4'h4, 4'hF, d);
    xl(8'h5A);
    st(s);
    check("R6 x_ld sets lane 3 full", {28'b0, s[23:20]}, 32'h8);
    hr(4'h4, 4'hF, d);
    check("R5 x_ld byte", d, 32'h5A02_0304);
    @(negedge clk);
    l_addr = 8'h1C; l_be = 4'b1000; l_wdata = 32'hEE00_0000; l_wr = 1'b1;
    x_byte = 8'h77; x_ld = 1'b1;
    @(posedge clk); #1 l_wr = 1'b0; x_ld = 1'b0;
    hr(4'h4, 4'hF, d);
    check("R5 local wins byte 3", d, 32'hEE02_0304);
    @(negedge clk);
    l_addr = 8'h1C; l_be = 4'b0001; l_wdata = 32'h0000_00AB; l_wr = 1'b1;
    x_byte = 8'h66; x_ld = 1'b1;
    @(posedge clk); #1 l_wr = 1'b0; x_ld = 1'b0;
    hr(4'h4, 4'hF, d);
    check("R5 disjoint lanes both land", d, 32'h6602_03AB);

    // R7 / R10 events, enables, irq
    hw(4'h8, 4'b0010, 32'h0000_0300);
    st(s);
    check("R9 pending cleared", {30'b0, s[9:8]}, 32'h0);
    check("R10 irq low", {31'b0, irq}, 32'h0);
    lr(8'h0C, 4'b0001, d);
    st(s);
    check("R7 read event pending", {30'b0, s[9:8]}, 32'h1);
    check("R10 irq masked", {31'b0, irq}, 32'h0);
    hw(4'h8, 4'b0001, 32'h0000_0001);
    check("R10 irq on enable", {31'b0, irq}, 32'h1);
    hw(4'h8, 4'b0010, 32'h0000_0100);
    check("R9 irq after clear", {31'b0, irq}, 32'h0);
    lw(8'h1C, 4'b0010, 32'h0000_1200);
    st(s);
    check("R7 write event pending", {30'b0, s[9:8]}, 32'h2);
    check("R10 other source masked", {31'b0, irq}, 32'h0);
    hw(4'h8, 4'b0001, 32'h0000_0002);
    check("R10 irq write source", {31'b0, irq}, 32'h1);

    // R8 local read of local-to-host word is quiet
    st(s0);
    lr(8'h1C, 4'hF, d);
    st(s);
    check("R8 control word stable", s, s0);
    check("R8 irq stable", {31'b0, irq}, 32'h1);

    // R9 clear semantics
    hw(4'h8, 4'b0010, 32'h0000_0000);
    st(s);
    check("R9 zero write keeps", {30'b0, s[9:8]}, 32'h2);
    hw(4'h8, 4'b0001, 32'h0000_0202);
    st(s);
    check("R9 lane 1 disabled keeps", {30'b0, s[9:8]}, 32'h2);
    @(negedge clk);
    l_addr = 8'h0C; l_be = 4'b0001; l_rd = 1'b1;
    h_addr = 4'h8; h_be = 4'b0010; h_wdata = 32'h0000_0100; h_wr = 1'b1;
    @(posedge clk); #1 l_rd = 1'b0; h_wr = 1'b0;
    st(s);
    check("R9 read event beats clear", {30'b0, s[9:8]}, 32'h3);
    @(negedge clk);
    l_addr = 8'h1C; l_be = 4'b0100; l_wdata = 32'h0; l_wr = 1'b1;
    h_addr = 4'h8; h_be = 4'b0010; h_wdata = 32'h0000_0300; h_wr = 1'b1;
    @(posedge clk); #1 l_wr = 1'b0; h_wr = 1'b0;
    st(s);
    check("R9 write event beats clear", {30'b0, s[9:8]}, 32'h2);

    // R6 set beats clear on full flags
    lw(8'h1C, 4'hF, 32'h0);
    @(negedge clk);
    h_addr = 4'h4; h_be = 4'hF; h_rd = 1'b1;
    l_addr = 8'h1C; l_be = 4'b0001; l_wdata = 32'h0; l_wr = 1'b1;
    @(posedge clk); #1 h_rd = 1'b0; l_wr = 1'b0;
    st(s);
    check("R6 out set beats clear", {28'b0, s[23:20]}, 32'h1);
    lr(8'h0C, 4'hF, d);
    @(negedge clk);
    h_addr = 4'h0; h_be = 4'b0100; h_wdata = 32'h0; h_wr = 1'b1;
    l_addr = 8'h0C; l_be = 4'b0100; l_rd = 1'b1;
    @(posedge clk); #1 h_wr = 1'b0; l_rd = 1'b0;
    st(s);
    check("R6 in set beats clear", {28'b0, s[19:16]}, 32'h4);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule